// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

The walker turns a linked list of 16-byte scatter-gather descriptors in memory into a series of transfer requests for a separate data mover. A packet sequencer starts a walk by pulsing `start_i` with the address of the first descriptor. The walker reads that descriptor as four 32-bit words over a simple request/acknowledge memory port. It decodes the buffer address, the length, the direction, the ordering hint and the DMA mode, and it presents one transfer on a valid/ready port. It then follows the descriptor's next pointer.

The length field counts 8-byte units. The walker converts it into a byte count before handing it on. A walk ends on the descriptor whose last flag is set, and the next pointer of that descriptor is never followed. The walker reports the end with a one-cycle `done_o` pulse. `err_o` rises with that pulse when the chain was malformed. Moving the data is left to the mover.

Top module: `sg_chain_walker`

## Requirements
- R1: A descriptor at pointer P is fetched as four word reads at addresses P, P+4, P+8 and P+12, in that order. Each read holds `mem_req_o` and `mem_addr_o` steady until the cycle in which `mem_ack_i` is high, and `mem_rdata_i` is taken in that cycle.
- R2: The word at P+0 is the buffer address and appears on `xfer_addr_o`. The word at P+4 is the length L in 8-byte units, and `xfer_bytes_o` equals L*8 (L shifted left by 3, with 35 bits so that no bit is lost).
- R3: In the word at P+8, bit 4 drives `xfer_ordered_o`, bit 5 drives `xfer_out_o` (1 = outbound, toward the disk), bit 7 is the last flag, and bits 11:8 drive `xfer_mode_o`. All other bits of this word are ignored.
- R4: Once `xfer_valid_o` rises, it and all transfer fields stay unchanged until `xfer_ready_i` is high. No memory read is issued while a transfer is pending.
- R5: When a transfer whose descriptor is not last is accepted, the next fetch starts at the next pointer held in the word at P+12.
- R6: When the transfer of a last descriptor is accepted, `done_o` is high for exactly the following cycle with `err_o` low, and `busy_o` is low from that cycle on. The next pointer of the last descriptor is not fetched, whatever its value.
- R7: A descriptor with a zero length field produces no transfer. It ends the walk with `done_o` and `err_o` both high.
- R8: A descriptor that is not last and has a zero next pointer produces no transfer. It ends the walk with `done_o` and `err_o` both high.
- R9: `start_i` is sampled only while the walker is idle. `busy_o` is high from the cycle after an accepted start until the end of the walk, and a start pulse during a walk has no effect on that walk.
- R10: After reset, `busy_o`, `done_o`, `err_o`, `mem_req_o` and `xfer_valid_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a walk (sampled when idle) |
| start_ptr_i | input | 32 | Address of the first descriptor |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_o | output | 1 | Malformed chain, valid with done_o |
| mem_req_o | output | 1 | Memory word read request |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_ack_i | input | 1 | Read completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| xfer_valid_o | output | 1 | Transfer request pending |
| xfer_ready_i | input | 1 | Mover accepts the request |
| xfer_addr_o | output | 32 | Buffer address |
| xfer_bytes_o | output | 35 | Byte count |
| xfer_out_o | output | 1 | Outbound direction |
| xfer_ordered_o | output | 1 | Ordered-transfer hint |
| xfer_mode_o | output | 4 | DMA mode |

## Verification
Some properties are checked on every cycle. A pending transfer holds steady, and memory reads never overlap a pending transfer. An unacknowledged read keeps its address, and an acknowledged read is followed by the next word address or by silence. `done_o` lasts one cycle, and `err_o` is never seen without it. Other properties depend on what memory holds, so only the bench's scenarios can show them. These cover correct field extraction and scaling, the order in which a chain is followed, the refusal to chase the final next pointer, and the early error ends at a chosen position in the chain. The bench also checks that a start pulse during a walk leaves the walk alone.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned SGW_WORD_W   = 32;
  localparam int unsigned SGW_ADDR_W   = 32;
  localparam int unsigned SGW_LEN_W    = 32;
  localparam int unsigned SGW_MODE_W   = 4;
  localparam int unsigned SGW_NWORDS   = 4;
  localparam int unsigned SGW_UNIT_SH  = 3;   // length unit = 8 bytes
  // flag byte bit positions (word 2, bits 7:0)
  localparam int unsigned FLG_ORD  = 4;
  localparam int unsigned FLG_OUT  = 5;
  localparam int unsigned FLG_LAST = 7;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_FETCH = 2'd1,
    WS_ISSUE = 2'd2
  } walk_state_e;
endpackage

// File: rtl/sgw_desc_fetch.sv
module sgw_desc_fetch #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NWORDS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic [ADDR_W-1:0]        go_ptr_i,
  output logic                     mem_req_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  input  logic                     mem_ack_i,
  input  logic [WORD_W-1:0]        mem_rdata_i,
  output logic                     desc_vld_o,
  output logic [NWORDS*WORD_W-1:0] desc_words_o
);
  localparam int unsigned BEAT_W   = $clog2(NWORDS);
  localparam int unsigned WB_SHIFT = $clog2(WORD_W/8);

  logic              active_q;
  logic [BEAT_W-1:0] beat_q;
  logic [ADDR_W-1:0] base_q;
  logic              vld_q;
  logic              last_beat;
  logic              take;

  assign last_beat  = (beat_q == BEAT_W'(NWORDS-1));
  assign take       = active_q && mem_ack_i;
  assign mem_req_o  = active_q;
  assign mem_addr_o = base_q + (ADDR_W'(beat_q) << WB_SHIFT);
  assign desc_vld_o = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      base_q   <= '0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        base_q   <= go_ptr_i;
      end else if (take) begin
        if (last_beat) begin
          active_q <= 1'b0;
          vld_q    <= 1'b1;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              word_q <= '0;
      else if (take && beat_q == BEAT_W'(w))    word_q <= mem_rdata_i;
    end
    assign desc_words_o[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LEN_W  = 32,
  parameter int unsigned MODE_W = 4,
  parameter int unsigned NWORDS = 4,
  localparam int unsigned BYTES_W = LEN_W + SGW_UNIT_SH
) (
  input  logic [NWORDS*WORD_W-1:0] words_i,
  output logic [ADDR_W-1:0]        addr_o,
  output logic [BYTES_W-1:0]       bytes_o,
  output logic                     ordered_o,
  output logic                     out_o,
  output logic                     last_o,
  output logic [MODE_W-1:0]        mode_o,
  output logic [ADDR_W-1:0]        next_o,
  output logic                     bad_len_o,
  output logic                     bad_link_o
);
  localparam int unsigned FLAG_LSB = 2*WORD_W;
  localparam int unsigned MODE_LSB = FLAG_LSB + 8;
  localparam int unsigned REST_W   = WORD_W - 8 - MODE_W;

  logic [7:0]       flags;
  logic [LEN_W-1:0] len_units;
  logic             unused_bits;

  assign flags     = words_i[FLAG_LSB +: 8];
  assign len_units = words_i[WORD_W +: LEN_W];

  assign addr_o    = words_i[0 +: ADDR_W];
  assign bytes_o   = {len_units, {SGW_UNIT_SH{1'b0}}};
  assign ordered_o = flags[FLG_ORD];
  assign out_o     = flags[FLG_OUT];
  assign last_o    = flags[FLG_LAST];
  assign mode_o    = words_i[MODE_LSB +: MODE_W];
  assign next_o    = words_i[3*WORD_W +: ADDR_W];

  assign bad_len_o  = (len_units == '0);
  assign bad_link_o = !last_o && (next_o == '0);

  assign unused_bits = ^{flags[3:0], flags[6], words_i[MODE_LSB+MODE_W +: REST_W]};
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int unsigned ADDR_W = SGW_ADDR_W,
  parameter int unsigned WORD_W = SGW_WORD_W,
  parameter int unsigned LEN_W  = SGW_LEN_W,
  parameter int unsigned MODE_W = SGW_MODE_W,
  localparam int unsigned NWORDS  = SGW_NWORDS,
  localparam int unsigned BYTES_W = LEN_W + SGW_UNIT_SH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  start_ptr_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_ack_i,
  input  logic [WORD_W-1:0]  mem_rdata_i,
  output logic               xfer_valid_o,
  input  logic               xfer_ready_i,
  output logic [ADDR_W-1:0]  xfer_addr_o,
  output logic [BYTES_W-1:0] xfer_bytes_o,
  output logic               xfer_out_o,
  output logic               xfer_ordered_o,
  output logic [MODE_W-1:0]  xfer_mode_o
);
  walk_state_e state_q, state_d;

  logic                     fetch_go;
  logic [ADDR_W-1:0]        fetch_ptr;
  logic                     desc_vld;
  logic [NWORDS*WORD_W-1:0] desc_words;
  logic                     d_last, d_bad_len, d_bad_link;
  logic [ADDR_W-1:0]        d_next;
  logic                     done_q, err_q;
  logic                     fin, fin_err;

  sgw_desc_fetch #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NWORDS(NWORDS)
  ) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (fetch_go),
    .go_ptr_i     (fetch_ptr),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ack_i    (mem_ack_i),
    .mem_rdata_i  (mem_rdata_i),
    .desc_vld_o   (desc_vld),
    .desc_words_o (desc_words)
  );

  sgw_desc_decode #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LEN_W(LEN_W), .MODE_W(MODE_W), .NWORDS(NWORDS)
  ) u_decode (
    .words_i    (desc_words),
    .addr_o     (xfer_addr_o),
    .bytes_o    (xfer_bytes_o),
    .ordered_o  (xfer_ordered_o),
    .out_o      (xfer_out_o),
    .last_o     (d_last),
    .mode_o     (xfer_mode_o),
    .next_o     (d_next),
    .bad_len_o  (d_bad_len),
    .bad_link_o (d_bad_link)
  );

  always_comb begin
    state_d   = state_q;
    fetch_go  = 1'b0;
    fetch_ptr = d_next;
    fin       = 1'b0;
    fin_err   = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        fetch_ptr = start_ptr_i;
        if (start_i) begin
          fetch_go = 1'b1;
          state_d  = WS_FETCH;
        end
      end
      WS_FETCH: begin
        if (desc_vld) begin
          if (d_bad_len || d_bad_link) begin
            fin     = 1'b1;
            fin_err = 1'b1;
            state_d = WS_IDLE;
          end else begin
            state_d = WS_ISSUE;
          end
        end
      end
      WS_ISSUE: begin
        if (xfer_ready_i) begin
          if (d_last) begin
            fin     = 1'b1;
            state_d = WS_IDLE;
          end else begin
            fetch_go = 1'b1;
            state_d  = WS_FETCH;
          end
        end
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      err_q   <= fin_err;
    end
  end

  assign busy_o       = (state_q != WS_IDLE);
  assign done_o       = done_q;
  assign err_o        = err_q;
  assign xfer_valid_o = (state_q == WS_ISSUE);
endmodule

// File: rtl/sgw_checker.sv
module sgw_checker #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned BYTES_W = 35
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o,
  input logic               mem_req_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_ack_i,
  input logic               xfer_valid_o,
  input logic               xfer_ready_i,
  input logic [ADDR_W-1:0]  xfer_addr_o,
  input logic [BYTES_W-1:0] xfer_bytes_o
);
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R1

  AST_MEM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i |=> !mem_req_o || (mem_addr_o == $past(mem_addr_o) + ADDR_W'(4))); // R1

  AST_XFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o) && $stable(xfer_bytes_o)); // R4

  AST_NO_FETCH_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && xfer_valid_o)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !xfer_valid_o); // R9
endmodule

bind sg_chain_walker sgw_checker #(.ADDR_W(ADDR_W), .BYTES_W(BYTES_W)) u_sgw_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .mem_ack_i    (mem_ack_i),
  .xfer_valid_o (xfer_valid_o),
  .xfer_ready_i (xfer_ready_i),
  .xfer_addr_o  (xfer_addr_o),
  .xfer_bytes_o (xfer_bytes_o)
);

// File: tb/sg_chain_walker_tb.sv
module sg_chain_walker_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] start_ptr_i = '0;
  logic        busy_o, done_o, err_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        xfer_valid_o;
  logic        xfer_ready_i = 1'b0;
  logic [31:0] xfer_addr_o;
  logic [34:0] xfer_bytes_o;
  logic        xfer_out_o, xfer_ordered_o;
  logic [3:0]  xfer_mode_o;

  always #10 clk_i = ~clk_i;

  sg_chain_walker dut_i (
    .clk_i, .rst_ni, .start_i, .start_ptr_i, .busy_o, .done_o, .err_o,
    .mem_req_o, .mem_addr_o, .mem_ack_i, .mem_rdata_i,
    .xfer_valid_o, .xfer_ready_i, .xfer_addr_o, .xfer_bytes_o,
    .xfer_out_o, .xfer_ordered_o, .xfer_mode_o
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] mem [0:255];
  logic [31:0] e_ptr  [16];
  logic [31:0] e_addr [16];
  logic [31:0] e_len  [16];
  bit          e_ord  [16];
  bit          e_out  [16];
  logic [3:0]  e_mode [16];
  int          n_exp_xfer = 0;
  int          xfer_idx = 0;
  int          f_desc = 0;
  int          f_beat = 0;
  bit          mon_on = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [34:0] exp_bytes(logic [31:0] len);
    return {3'b000, len} * 35'd8;
  endfunction

  // memory and mover models; grant decided at negedge, consumed at next posedge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      mem_ack_i   = ($urandom % 4) != 0;
      mem_rdata_i = mem[mem_addr_o[9:2]];
      if (mon_on && mem_req_o && mem_ack_i) begin
        check(mem_addr_o == e_ptr[f_desc] + 32'(4*f_beat), "R1", "fetch address",
              64'(mem_addr_o), 64'(e_ptr[f_desc] + 32'(4*f_beat)));
        f_beat++;
        if (f_beat == 4) begin f_beat = 0; f_desc++; end
      end
      if (mem_req_o && xfer_valid_o)
        check(0, "R4", "fetch while transfer pending", 1, 0);
      xfer_ready_i = ($urandom % 3) != 0;
      if (mon_on && xfer_valid_o && xfer_ready_i) begin
        if (xfer_idx >= n_exp_xfer) begin
          check(0, "R7", "unexpected transfer", 64'(xfer_idx), 64'(n_exp_xfer));
        end else begin
          check(xfer_addr_o == e_addr[xfer_idx], "R2", "buffer address",
                64'(xfer_addr_o), 64'(e_addr[xfer_idx]));
          check(xfer_bytes_o == exp_bytes(e_len[xfer_idx]), "R2", "byte count",
                64'(xfer_bytes_o), 64'(exp_bytes(e_len[xfer_idx])));
          check({xfer_out_o, xfer_ordered_o, xfer_mode_o} ==
                {e_out[xfer_idx], e_ord[xfer_idx], e_mode[xfer_idx]}, "R3", "dir/ord/mode",
                64'({xfer_out_o, xfer_ordered_o, xfer_mode_o}),
                64'({e_out[xfer_idx], e_ord[xfer_idx], e_mode[xfer_idx]}));
        end
        xfer_idx++;
      end
    end else begin
      mem_ack_i    = 1'b0;
      xfer_ready_i = 1'b0;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      check(0, "R9", "watchdog expired", 64'(cyc), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [31:0] pick_len(int sel);
    case (sel % 6)
      0: return 32'd1;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      default: return ($urandom % 32'h0010_0000) + 1;
    endcase
  endfunction

  // kind 0: good chain; 1: zero length at bad; 2: non-last with zero next at bad
  task automatic build(int n, int kind, int bad, int salt);
    for (int i = 0; i < n; i++) e_ptr[i] = 32'((((salt * 7) + i * 13) % 63) + 1) * 32'd16;
    for (int i = 0; i < n; i++) begin
      bit last = (i == n - 1);
      logic [31:0] nxt;
      logic [7:0]  flg;
      logic [7:0]  mbyte;
      e_addr[i] = $urandom;
      e_len[i]  = pick_len($urandom % 100);
      e_ord[i]  = $urandom % 2;
      e_out[i]  = $urandom % 2;
      e_mode[i] = $urandom % 16;
      nxt = last ? 32'hFFFF_FFF0 : e_ptr[i+1];
      if (kind == 1 && i == bad) e_len[i] = 32'd0;
      if (kind == 2 && i == bad) begin last = 0; nxt = 32'd0; end
      // ignored bits randomised to show they have no effect (R3)
      flg   = {last, 1'($urandom), e_out[i], e_ord[i], 4'($urandom)};
      mbyte = {4'($urandom), e_mode[i]};
      mem[e_ptr[i][9:2]]       = e_addr[i];
      mem[e_ptr[i][9:2] + 1]   = e_len[i];
      mem[e_ptr[i][9:2] + 2]   = {16'($urandom), mbyte, flg};
      mem[e_ptr[i][9:2] + 3]   = nxt;
    end
  endtask

  task automatic run(int n, int kind, int bad, int salt, bit poke_start);
    int t;
    int ndesc;
    string rq;
    build(n, kind, bad, salt);
    ndesc      = (kind == 0) ? n : bad + 1;
    n_exp_xfer = (kind == 0) ? n : bad;
    xfer_idx = 0; f_desc = 0; f_beat = 0; mon_on = 1;
    @(negedge clk_i);
    start_i = 1'b1; start_ptr_i = e_ptr[0];
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9", "busy after start", 64'(busy_o), 1);
    if (poke_start) begin
      repeat (5) @(negedge clk_i);
      start_i = 1'b1; start_ptr_i = 32'h0000_0200;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    t = 0;
    while (!done_o && t < 20000) begin @(negedge clk_i); t++; end
    rq = (kind == 0) ? "R6" : (kind == 1) ? "R7" : "R8";
    check(done_o == 1'b1, rq, "done seen", 64'(done_o), 1);
    check(err_o == (kind != 0), rq, "error flag", 64'(err_o), 64'(kind != 0));
    check(busy_o == 1'b0, rq, "idle at done", 64'(busy_o), 0);
    check(xfer_idx == n_exp_xfer, rq, "transfer count", 64'(xfer_idx), 64'(n_exp_xfer));
    check(f_desc == ndesc, "R5", "descriptors fetched", 64'(f_desc), 64'(ndesc));
    @(negedge clk_i);
    check(done_o == 1'b0 && err_o == 1'b0, "R6", "done is one cycle", 64'({done_o, err_o}), 0);
    repeat (3) @(negedge clk_i);
    check(f_desc == ndesc && !mem_req_o, "R6", "no fetch after end", 64'(f_desc), 64'(ndesc));
    mon_on = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !err_o && !mem_req_o && !xfer_valid_o, "R10", "reset outputs",
          64'({busy_o, done_o, err_o, mem_req_o, xfer_valid_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !mem_req_o && !xfer_valid_o, "R10", "idle after reset",
          64'({busy_o, mem_req_o, xfer_valid_o}), 0);

    run(1, 0, 0, 1, 0);   // R6 single last descriptor, garbage next ignored
    run(4, 0, 0, 2, 1);   // R9 start during walk ignored
    run(3, 1, 0, 3, 0);   // R7 zero length on first
    run(5, 1, 4, 4, 0);   // R7 zero length on last
    run(4, 2, 1, 5, 0);   // R8 broken link mid-chain
    run(1, 2, 0, 6, 0);   // R8 single non-last with zero next
    for (int k = 0; k < 24; k++) begin
      int n = 1 + ($urandom % 8);
      int kind = ($urandom % 4 == 0) ? 1 + ($urandom % 2) : 0;
      run(n, kind, $urandom % n, 10 + k, ($urandom % 3) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule